// File: doc/BRIEF.md
# Chopping Current Limit Controller

This block governs the gate of one bridge output stage while a motor load is driven. It watches two synchronous comparator flags: a limit flag that says the load current has reached its regulation ceiling, and a short-circuit flag that says the current is far above anything a healthy load draws. When the limit flag is seen, the stage is turned off for a fixed number of clocks. It is then turned back on, and the limit flag is ignored for a further fixed number of clocks so that the switching transient cannot retrigger it. The result is a self-timed chop whose rate follows the load.

A short-circuit indication is handled differently. If the flag stays high for a run of consecutive clocks while the stage conducts and the blanking window is not active, the stage is turned off and a latched fault is raised for the fault sequencer. The latch and all timers are released only when the drive command for the stage is withdrawn. A one-clock event pulse marks the start of every chop so that the status logic can count limitation events. The off, blanking and short-circuit persistence intervals are given as nanosecond parameters. The block converts them to clock counts from a clock-frequency parameter.

Top module: `chop_ilim`

## Requirements
- R1: While reset is high, and in the first cycle after it with the drive command low, gate_on, oc_evt and sc_fault are all 0.
- R2: When drive_en is sampled low, gate_on and sc_fault are 0 from the next clock onward and any chop or fault in progress is abandoned. When drive_en is sampled high again, gate_on is 1 one clock later.
- R3: When lim_flag is sampled high while the stage conducts, outside blanking and with sc_flag low, gate_on goes to 0 at the next clock. In that same cycle oc_evt is 1 for exactly one clock.
- R4: After a chop starts, gate_on stays 0 for exactly OFF_CYC clocks, counting the cycle in which oc_evt is 1. lim_flag has no effect during this time.
- R5: After the off-time, gate_on is 1 and lim_flag is ignored for BLANK_CYC clocks. A limit flag sampled in the clock after that window starts a new chop.
- R6: With lim_flag held high, the stage chops with a period of OFF_CYC+BLANK_CYC+1 clocks. Each period has one oc_evt pulse and BLANK_CYC+1 clocks with gate_on at 1.
- R7: If sc_flag is sampled high on SC_CYC consecutive clocks while the stage conducts outside blanking, gate_on goes to 0 and sc_fault to 1 at the last of those clocks. A shorter run has no effect. While sc_flag is high the limit flag does not start a chop.
- R8: sc_flag is ignored during the off-time and the blanking window.
- R9: sc_fault stays 1 and gate_on stays 0 until drive_en is sampled low. No oc_evt pulse occurs while sc_fault is 1.
- R10: OFF_CYC, BLANK_CYC and SC_CYC equal CLK_HZ times OFF_NS, BLANK_NS and SC_NS respectively, divided by 10^9 and rounded down, with a minimum of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| drive_en | input | 1 | Drive command for this output stage |
| lim_flag | input | 1 | Synchronous current-limit comparator flag |
| sc_flag | input | 1 | Synchronous short-circuit comparator flag |
| gate_on | output | 1 | Gate enable for the active output stage (registered) |
| oc_evt | output | 1 | One-clock pulse at the start of each chop (registered) |
| sc_fault | output | 1 | Latched short-circuit shutdown (registered) |

## Verification
The bench builds the block with CLK_HZ of 1 MHz, OFF_NS of 4000, BLANK_NS of 3000 and SC_NS of 2000. These settings give an off-time of 4 clocks, a blanking window of 3 clocks and a short-circuit persistence of 2 clocks. With windows this short, a one-clock limit pulse can be placed at every offset of the chop cycle, from the first off clock to the first evaluated clock after blanking. Short-circuit runs of every length around the persistence threshold can also be tried, alone and together with the limit flag. The bench also withdraws the drive command in the middle of a chop and during a latched fault, and checks that every interval restarts from zero.

// File: rtl/ilim_pkg.sv
package ilim_pkg;

  typedef enum logic [2:0] {
    ILIM_IDLE  = 3'd0,
    ILIM_COND  = 3'd1,
    ILIM_OFF   = 3'd2,
    ILIM_BLANK = 3'd3,
    ILIM_TRIP  = 3'd4
  } ilim_state_e;

  function automatic int ns_to_cycles(input longint clk_hz, input longint ns);
    longint c;
    c = (clk_hz * ns) / 64'd1_000_000_000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

endpackage

// File: rtl/ilim_span_cnt.sv
module ilim_span_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] last,
  output logic         hit
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (en && !hit) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign hit = en && (cnt == last);

endmodule

// File: rtl/ilim_ctrl_fsm.sv
module ilim_ctrl_fsm
  import ilim_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic drive_en,
  input  logic lim_flag,
  input  logic sc_flag,
  input  logic ph_hit,
  input  logic sc_hit,
  output logic ph_en,
  output logic ph_clr,
  output logic ph_sel_off,
  output logic sc_en,
  output logic sc_clr,
  output logic gate_on,
  output logic oc_evt,
  output logic sc_fault
);

  ilim_state_e st, nx;
  logic        chop;

  always_comb begin
    nx   = st;
    chop = 1'b0;
    unique case (st)
      ILIM_IDLE:  nx = ILIM_COND;
      ILIM_COND: begin
        if (sc_flag) begin
          if (sc_hit) nx = ILIM_TRIP;
        end else if (lim_flag) begin
          nx   = ILIM_OFF;
          chop = 1'b1;
        end
      end
      ILIM_OFF:   if (ph_hit) nx = ILIM_BLANK;
      ILIM_BLANK: if (ph_hit) nx = ILIM_COND;
      ILIM_TRIP:  nx = ILIM_TRIP;
      default:    nx = ILIM_IDLE;
    endcase
    if (!drive_en) begin
      nx   = ILIM_IDLE;
      chop = 1'b0;
    end
  end

  assign ph_en      = (st == ILIM_OFF) || (st == ILIM_BLANK);
  assign ph_clr     = !drive_en || (nx != st);
  assign ph_sel_off = (st == ILIM_OFF);
  assign sc_en      = drive_en && (st == ILIM_COND) && sc_flag;
  assign sc_clr     = !sc_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ILIM_IDLE;
      gate_on  <= 1'b0;
      oc_evt   <= 1'b0;
      sc_fault <= 1'b0;
    end else begin
      st       <= nx;
      gate_on  <= (nx == ILIM_COND) || (nx == ILIM_BLANK);
      oc_evt   <= chop;
      sc_fault <= (nx == ILIM_TRIP);
    end
  end

endmodule

// File: rtl/chop_ilim.sv
module chop_ilim
  import ilim_pkg::*;
#(
  parameter int CLK_HZ   = 100_000_000,
  parameter int OFF_NS   = 17_000,
  parameter int BLANK_NS = 11_500,
  parameter int SC_NS    = 10_000
) (
  input  logic clk,
  input  logic rst,
  input  logic drive_en,
  input  logic lim_flag,
  input  logic sc_flag,
  output logic gate_on,
  output logic oc_evt,
  output logic sc_fault
);

  localparam int OFF_CYC   = ns_to_cycles(longint'(CLK_HZ), longint'(OFF_NS));
  localparam int BLANK_CYC = ns_to_cycles(longint'(CLK_HZ), longint'(BLANK_NS));
  localparam int SC_CYC    = ns_to_cycles(longint'(CLK_HZ), longint'(SC_NS));
  localparam int PH_MAX    = (OFF_CYC > BLANK_CYC) ? OFF_CYC : BLANK_CYC;
  localparam int PW        = (PH_MAX > 1) ? $clog2(PH_MAX) : 1;
  localparam int SW        = (SC_CYC > 1) ? $clog2(SC_CYC) : 1;
  localparam logic [PW-1:0] OFF_LAST   = PW'(OFF_CYC - 1);
  localparam logic [PW-1:0] BLANK_LAST = PW'(BLANK_CYC - 1);
  localparam logic [SW-1:0] SC_LAST    = SW'(SC_CYC - 1);

  logic ph_en, ph_clr, ph_sel_off, ph_hit;
  logic sc_en, sc_clr, sc_hit;
  logic [PW-1:0] ph_last;

  assign ph_last = ph_sel_off ? OFF_LAST : BLANK_LAST;

  ilim_ctrl_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .drive_en   (drive_en),
    .lim_flag   (lim_flag),
    .sc_flag    (sc_flag),
    .ph_hit     (ph_hit),
    .sc_hit     (sc_hit),
    .ph_en      (ph_en),
    .ph_clr     (ph_clr),
    .ph_sel_off (ph_sel_off),
    .sc_en      (sc_en),
    .sc_clr     (sc_clr),
    .gate_on    (gate_on),
    .oc_evt     (oc_evt),
    .sc_fault   (sc_fault)
  );

  ilim_span_cnt #(.W(PW)) u_phase (
    .clk  (clk),
    .rst  (rst),
    .clr  (ph_clr),
    .en   (ph_en),
    .last (ph_last),
    .hit  (ph_hit)
  );

  ilim_span_cnt #(.W(SW)) u_short (
    .clk  (clk),
    .rst  (rst),
    .clr  (sc_clr),
    .en   (sc_en),
    .last (SC_LAST),
    .hit  (sc_hit)
  );

endmodule

// File: rtl/ilim_chk.sv
module ilim_chk #(
  parameter int OFF_CYC   = 4,
  parameter int BLANK_CYC = 3
) (
  input logic clk,
  input logic rst,
  input logic drive_en,
  input logic gate_on,
  input logic oc_evt,
  input logic sc_fault
);

  logic [31:0] low_run;
  logic [31:0] since_oc;

  always_ff @(posedge clk) begin
    if (rst || !drive_en || sc_fault) begin
      low_run <= '0;
    end else if (oc_evt) begin
      low_run <= 32'd1;
    end else if (!gate_on && low_run != 0) begin
      low_run <= low_run + 32'd1;
    end else begin
      low_run <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !drive_en) begin
      since_oc <= '1;
    end else if (oc_evt) begin
      since_oc <= '0;
    end else if (since_oc != '1) begin
      since_oc <= since_oc + 32'd1;
    end
  end

  AST_OC_GATE_OFF: assert property (@(posedge clk) disable iff (rst) oc_evt |-> !gate_on); // R3
  AST_OC_SINGLE: assert property (@(posedge clk) disable iff (rst) oc_evt |=> !oc_evt); // R3
  AST_OFF_LENGTH: assert property (@(posedge clk) disable iff (rst) (gate_on && low_run != 0) |-> (low_run == 32'(OFF_CYC))); // R4
  AST_CHOP_SPACING: assert property (@(posedge clk) disable iff (rst) oc_evt |-> (since_oc >= 32'(OFF_CYC + BLANK_CYC))); // R5
  AST_FAULT_GATE: assert property (@(posedge clk) disable iff (rst) sc_fault |-> !gate_on); // R7
  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (rst) (sc_fault && drive_en) |=> sc_fault); // R9
  AST_FAULT_NO_OC: assert property (@(posedge clk) disable iff (rst) sc_fault |-> !oc_evt); // R9
  AST_CMD_RELEASE: assert property (@(posedge clk) disable iff (rst) !drive_en |=> (!gate_on && !sc_fault)); // R2

endmodule

bind chop_ilim ilim_chk #(.OFF_CYC(OFF_CYC), .BLANK_CYC(BLANK_CYC)) u_ilim_chk (
  .clk      (clk),
  .rst      (rst),
  .drive_en (drive_en),
  .gate_on  (gate_on),
  .oc_evt   (oc_evt),
  .sc_fault (sc_fault)
);

// File: tb/tb_chop_ilim.sv
module tb_chop_ilim;

  localparam int CLK_HZ   = 1_000_000;
  localparam int OFF_NS   = 4000;
  localparam int BLANK_NS = 3000;
  localparam int SC_NS    = 2000;
  // R10: expected counts from the nanosecond settings
  localparam int OFF = (CLK_HZ / 1000) * OFF_NS / 1_000_000;
  localparam int BLK = (CLK_HZ / 1000) * BLANK_NS / 1_000_000;
  localparam int SCD = (CLK_HZ / 1000) * SC_NS / 1_000_000;
  localparam int PER = OFF + BLK + 1;

  logic clk = 1'b0;
  logic rst, drive_en, lim_flag, sc_flag;
  logic gate_on, oc_evt, sc_fault;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  chop_ilim #(
    .CLK_HZ(CLK_HZ), .OFF_NS(OFF_NS), .BLANK_NS(BLANK_NS), .SC_NS(SC_NS)
  ) dut (
    .clk(clk), .rst(rst), .drive_en(drive_en), .lim_flag(lim_flag),
    .sc_flag(sc_flag), .gate_on(gate_on), .oc_evt(oc_evt), .sc_fault(sc_fault)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  // start a chop from the conducting state; returns at sample 0 of the chop
  task automatic chop_now();
    lim_flag = 1'b1;
    cyc();
    lim_flag = 1'b0;
    chk("R3 oc_evt at chop", int'(oc_evt), 1);
    chk("R3 gate off at chop", int'(gate_on), 0);
  endtask

  task automatic settle();
    for (int i = 0; i < PER + 1; i++) cyc();
  endtask

  initial begin
    int n_oc, n_hi;
    rst = 1'b1; drive_en = 1'b0; lim_flag = 1'b0; sc_flag = 1'b0;
    repeat (3) cyc();
    chk("R1 gate in reset", int'(gate_on), 0);
    chk("R1 oc in reset", int'(oc_evt), 0);
    chk("R1 fault in reset", int'(sc_fault), 0);
    rst = 1'b0;
    cyc();
    chk("R1 gate after reset", int'(gate_on), 0);

    drive_en = 1'b1;
    cyc();
    chk("R2 gate on after command", int'(gate_on), 1);
    cyc();

    // R4 R5 R10: per-cycle gate shape of one chop
    chop_now();
    for (int j = 1; j <= OFF + BLK + 2; j++) begin
      cyc();
      chk("R4 R5 R10 gate shape", int'(gate_on), (j >= OFF) ? 1 : 0);
      chk("R4 R5 oc quiet", int'(oc_evt), 0);
    end

    // R4 R5: one-clock limit pulse at every offset of the chop cycle
    for (int p = 0; p <= OFF + BLK + 1; p++) begin
      chop_now();
      for (int j = 1; j <= p; j++) cyc();
      lim_flag = 1'b1;
      cyc();
      lim_flag = 1'b0;
      chk((p < OFF) ? "R4 limit ignored in off" : "R5 limit after blank",
          int'(oc_evt), (p >= OFF + BLK) ? 1 : 0);
      settle();
    end

    // R6: limit held high
    n_oc = 0; n_hi = 0;
    lim_flag = 1'b1;
    for (int j = 0; j < 3 * PER; j++) begin
      cyc();
      n_oc += int'(oc_evt);
      n_hi += int'(gate_on);
    end
    lim_flag = 1'b0;
    chk("R6 chop count", n_oc, 3);
    chk("R6 on clocks", n_hi, 3 * (BLK + 1));
    settle();

    // R7 R9 R2: short runs of each length
    for (int len = 1; len <= SCD + 1; len++) begin
      sc_flag = 1'b1;
      for (int j = 1; j <= len; j++) begin
        cyc();
        chk("R7 fault timing", int'(sc_fault), (j >= SCD) ? 1 : 0);
        chk("R7 gate timing", int'(gate_on), (j >= SCD) ? 0 : 1);
      end
      sc_flag = 1'b0;
      cyc(); cyc();
      chk("R7 fault after run", int'(sc_fault), (len >= SCD) ? 1 : 0);
      if (len >= SCD) begin
        lim_flag = 1'b1;
        cyc();
        lim_flag = 1'b0;
        chk("R9 no oc in fault", int'(oc_evt), 0);
        cyc(); cyc();
        chk("R9 fault latched", int'(sc_fault), 1);
        chk("R9 gate held off", int'(gate_on), 0);
        drive_en = 1'b0;
        cyc();
        chk("R2 fault cleared", int'(sc_fault), 0);
        chk("R2 gate off", int'(gate_on), 0);
        drive_en = 1'b1;
        cyc();
        chk("R2 gate back on", int'(gate_on), 1);
      end
      cyc();
    end

    // R7: short flag takes precedence over the limit flag
    sc_flag = 1'b1; lim_flag = 1'b1;
    for (int j = 1; j <= SCD; j++) begin
      cyc();
      chk("R7 no chop during short", int'(oc_evt), 0);
    end
    sc_flag = 1'b0; lim_flag = 1'b0;
    chk("R7 fault with limit high", int'(sc_fault), 1);
    drive_en = 1'b0; cyc();
    drive_en = 1'b1; cyc(); cyc();

    // R8: short flag held through off-time and blanking
    chop_now();
    sc_flag = 1'b1;
    for (int j = 1; j <= OFF + BLK - 1; j++) cyc();
    sc_flag = 1'b0;
    for (int j = 0; j < 3; j++) begin
      cyc();
      chk("R8 no fault from blanked short", int'(sc_fault), 0);
      chk("R8 gate conducts", int'(gate_on), 1);
    end

    // R2: abort a chop, then full off-time on the next one
    chop_now();
    cyc();
    drive_en = 1'b0;
    cyc();
    chk("R2 gate off on abort", int'(gate_on), 0);
    drive_en = 1'b1;
    cyc();
    chk("R2 gate on after abort", int'(gate_on), 1);
    cyc();
    chop_now();
    for (int j = 1; j <= OFF; j++) begin
      cyc();
      chk("R2 R4 fresh off-time", int'(gate_on), (j >= OFF) ? 1 : 0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule